// File: doc/BRIEF.md
# Reservation Monitor for Atomic Load/Store Pairs

This block holds the one reservation that a core keeps for atomic read-modify-write sequences built from a reserving load and a conditional store. A reserving load of 1, 2, 4 or 8 bytes arms the reservation and records the access size and the effective address. A later conditional store checks that reservation and either allows its memory write or drops it. Every conditional store leaves the monitor unarmed, whether or not it succeeds.

The core presents a one-cycle instruction strobe with the decoded 10-bit opcode, the effective address and the current summary-overflow bit. A coherence agent can signal a remote write to a doubleword-aligned granule with a snoop strobe and address. All three outputs are registered. They are valid in the cycle after the conditional store is strobed. The 4-bit condition value has the success flag in bit 1 and the summary-overflow bit in bit 0.

Top module: `lrsc_monitor`

## Requirements
- R1: A strobed reserving load arms the reservation, and records its size. The opcodes are 52 (1 byte), 116 (2 bytes), 20 (4 bytes) and 84 (8 bytes).
- R2: A reserving load stores its full effective address as the reserved address. It replaces any reservation already held.
- R3: The conditional-store opcodes are 694 (1 byte), 726 (2 bytes), 150 (4 bytes) and 214 (8 bytes). A conditional store succeeds only when three things hold: the reservation is armed, the recorded size equals the store size, and the recorded address equals the store address in every bit.
- R4: In the cycle after a conditional store, `cr_field` equals {2'b00, success, so_bit}, so 4'b0010 or 4'b0000, ORed with the overflow bit. In every other cycle it holds its previous value.
- R5: `wr_permit` and `sc_success` are both high in the cycle after a successful conditional store. They are low in all other cycles.
- R6: Every conditional store disarms the reservation, whether it succeeds or fails.
- R7: A snoop whose address equals the reserved address with bits [2:0] ignored disarms the reservation. A snoop to any other granule has no effect.
- R8: If a reserving load and a matching snoop arrive in the same cycle, the load wins and the reservation stays armed. A conditional store that arrives with a matching snoop fails.
- R9: The block ignores any opcode outside the eight listed above, and any opcode presented while the strobe is low.
- R10: A synchronous active-high reset disarms the reservation and drives all three outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_vld | input | 1 | Instruction strobe, one cycle per instruction |
| opcode | input | 10 | Decoded extended opcode |
| eff_addr | input | 64 | Effective address of the access |
| so_bit | input | 1 | Summary-overflow bit merged into the condition value |
| snoop_vld | input | 1 | Remote-write invalidate strobe |
| snoop_addr | input | 64 | Address of the remote write |
| wr_permit | output | 1 | Memory write allowed for this conditional store |
| sc_success | output | 1 | Conditional store succeeded |
| cr_field | output | 4 | Condition value of the last conditional store |

## Verification
The assertions check these on every cycle:
- Any conditional store leaves the reservation unarmed. A reserving load arms it with the size it carries.
- A matching snoop without a load disarms the reservation.
- A permitted write always follows a conditional store that saw a matching size and address.
- The condition value changes only after a conditional store.

Some behaviours only the bench's scenarios can show, because they depend on the order of instructions:
- A newer reservation replaces an older one.
- A snoop address that differs only in its low three bits still matches.
- A load and a snoop in the same cycle resolve in favour of the load.
- Ignored opcodes leave an armed reservation intact.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  localparam int OPC_W = 10;

  typedef enum logic [1:0] {
    OPK_NONE = 2'd0,
    OPK_LR   = 2'd1,
    OPK_SC   = 2'd2
  } op_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  typedef struct packed {
    op_kind_e  kind;
    acc_size_e size;
  } op_dec_t;

  localparam logic [OPC_W-1:0] OPC_LR_B = 10'd52;
  localparam logic [OPC_W-1:0] OPC_LR_H = 10'd116;
  localparam logic [OPC_W-1:0] OPC_LR_W = 10'd20;
  localparam logic [OPC_W-1:0] OPC_LR_D = 10'd84;
  localparam logic [OPC_W-1:0] OPC_SC_B = 10'd694;
  localparam logic [OPC_W-1:0] OPC_SC_H = 10'd726;
  localparam logic [OPC_W-1:0] OPC_SC_W = 10'd150;
  localparam logic [OPC_W-1:0] OPC_SC_D = 10'd214;

endpackage

// File: rtl/lrsc_decoder.sv
module lrsc_decoder
  import lrsc_pkg::*;
(
  input  logic             strobe,
  input  logic [OPC_W-1:0] opcode,
  output op_dec_t          dec
);

  always_comb begin
    dec.kind = OPK_NONE;
    dec.size = SZ_BYTE;
    if (strobe) begin
      unique case (opcode)
        OPC_LR_B: begin dec.kind = OPK_LR; dec.size = SZ_BYTE; end
        OPC_LR_H: begin dec.kind = OPK_LR; dec.size = SZ_HALF; end
        OPC_LR_W: begin dec.kind = OPK_LR; dec.size = SZ_WORD; end
        OPC_LR_D: begin dec.kind = OPK_LR; dec.size = SZ_DBL;  end
        OPC_SC_B: begin dec.kind = OPK_SC; dec.size = SZ_BYTE; end
        OPC_SC_H: begin dec.kind = OPK_SC; dec.size = SZ_HALF; end
        OPC_SC_W: begin dec.kind = OPK_SC; dec.size = SZ_WORD; end
        OPC_SC_D: begin dec.kind = OPK_SC; dec.size = SZ_DBL;  end
        default:  begin dec.kind = OPK_NONE; dec.size = SZ_BYTE; end
      endcase
    end
  end

  // R9: nothing decodes while the strobe is low
  always_comb begin
    a_idle_none_r9: assert (strobe || dec.kind == OPK_NONE);
  end

endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv
  import lrsc_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int GRAN_LSB = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lr_fire,
  input  acc_size_e         lr_size,
  input  logic [ADDR_W-1:0] lr_addr,
  input  logic              sc_fire,
  input  logic              snoop_vld,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              live_vld,
  output acc_size_e         resv_size,
  output logic [ADDR_W-1:0] resv_addr
);

  localparam int GRAN_HI = ADDR_W - 1;

  logic              vld_q;
  acc_size_e         size_q;
  logic [ADDR_W-1:0] addr_q;
  logic              snoop_hit;

  assign snoop_hit = snoop_vld && vld_q &&
                     (snoop_addr[GRAN_HI:GRAN_LSB] == addr_q[GRAN_HI:GRAN_LSB]);

  // A matching snoop in the same cycle already voids the reservation for a store
  assign live_vld  = vld_q && !snoop_hit;
  assign resv_size = size_q;
  assign resv_addr = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      size_q <= SZ_BYTE;
      addr_q <= '0;
    end else if (lr_fire) begin
      vld_q  <= 1'b1;
      size_q <= lr_size;
      addr_q <= lr_addr;
    end else if (sc_fire || snoop_hit) begin
      vld_q  <= 1'b0;
    end
  end

  p_sc_disarms_r6: assert property (@(posedge clk) disable iff (rst)
    sc_fire |=> !vld_q);

  p_lr_arms_r1: assert property (@(posedge clk) disable iff (rst)
    lr_fire |=> (vld_q && size_q == $past(lr_size)));

  p_lr_addr_r2: assert property (@(posedge clk) disable iff (rst)
    lr_fire |=> (addr_q == $past(lr_addr)));

  p_snoop_kill_r7: assert property (@(posedge clk) disable iff (rst)
    (snoop_hit && !lr_fire) |=> !vld_q);

endmodule

// File: rtl/lrsc_sc_eval.sv
module lrsc_sc_eval
  import lrsc_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sc_fire,
  input  acc_size_e         sc_size,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              so_bit,
  input  logic              live_vld,
  input  acc_size_e         resv_size,
  input  logic [ADDR_W-1:0] resv_addr,
  output logic              wr_permit,
  output logic              sc_success,
  output logic [CR_W-1:0]   cr_field
);

  logic size_ok;
  logic addr_ok;
  logic pass;

  assign size_ok = (resv_size == sc_size);
  assign addr_ok = (resv_addr == sc_addr);
  assign pass    = sc_fire && live_vld && size_ok && addr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_permit  <= 1'b0;
      sc_success <= 1'b0;
      cr_field   <= '0;
    end else begin
      wr_permit  <= pass;
      sc_success <= pass;
      if (sc_fire) begin
        cr_field <= {{(CR_W-2){1'b0}}, pass, so_bit};
      end
    end
  end

  p_cr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !sc_fire |=> $stable(cr_field));

  p_cr_so_r4: assert property (@(posedge clk) disable iff (rst)
    sc_fire |=> (cr_field[0] == $past(so_bit)));

  p_success_bit_r4: assert property (@(posedge clk) disable iff (rst)
    sc_success |-> cr_field[1]);

  p_needs_match_r3: assert property (@(posedge clk) disable iff (rst)
    wr_permit |-> $past(sc_fire && size_ok && addr_ok));

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int GRAN_LSB = 3,
  parameter int CR_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_vld,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic              so_bit,
  input  logic              snoop_vld,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              wr_permit,
  output logic              sc_success,
  output logic [CR_W-1:0]   cr_field
);

  op_dec_t           dec;
  logic              lr_fire;
  logic              sc_fire;
  logic              live_vld;
  acc_size_e         resv_size;
  logic [ADDR_W-1:0] resv_addr;

  lrsc_decoder u_dec (
    .strobe (instr_vld),
    .opcode (opcode),
    .dec    (dec)
  );

  assign lr_fire = (dec.kind == OPK_LR);
  assign sc_fire = (dec.kind == OPK_SC);

  lrsc_resv #(
    .ADDR_W   (ADDR_W),
    .GRAN_LSB (GRAN_LSB)
  ) u_resv (
    .clk        (clk),
    .rst        (rst),
    .lr_fire    (lr_fire),
    .lr_size    (dec.size),
    .lr_addr    (eff_addr),
    .sc_fire    (sc_fire),
    .snoop_vld  (snoop_vld),
    .snoop_addr (snoop_addr),
    .live_vld   (live_vld),
    .resv_size  (resv_size),
    .resv_addr  (resv_addr)
  );

  lrsc_sc_eval #(
    .ADDR_W (ADDR_W),
    .CR_W   (CR_W)
  ) u_eval (
    .clk        (clk),
    .rst        (rst),
    .sc_fire    (sc_fire),
    .sc_size    (dec.size),
    .sc_addr    (eff_addr),
    .so_bit     (so_bit),
    .live_vld   (live_vld),
    .resv_size  (resv_size),
    .resv_addr  (resv_addr),
    .wr_permit  (wr_permit),
    .sc_success (sc_success),
    .cr_field   (cr_field)
  );

  p_permit_after_sc_r5: assert property (@(posedge clk) disable iff (rst)
    wr_permit |-> $past(instr_vld));

  p_permit_success_r5: assert property (@(posedge clk) disable iff (rst)
    wr_permit == sc_success);

  p_reset_quiet_r10: assert property (@(posedge clk)
    $past(rst) |-> (!wr_permit && !sc_success && cr_field == '0));

endmodule

// File: tb/lrsc_monitor_tb.sv
`timescale 1ns/1ps
module lrsc_monitor_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_vld = 1'b0;
  logic [9:0]  opcode = '0;
  logic [63:0] eff_addr = '0;
  logic        so_bit = 1'b0;
  logic        snoop_vld = 1'b0;
  logic [63:0] snoop_addr = '0;
  logic        wr_permit;
  logic        sc_success;
  logic [3:0]  cr_field;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R10";

  // reference state
  bit          m_vld = 1'b0;
  int          m_len = 0;
  logic [63:0] m_addr = '0;
  bit          e_pass = 1'b0;
  logic [3:0]  e_cr = 4'b0000;

  always #4 clk = ~clk;

  lrsc_monitor u_dut (
    .clk(clk), .rst(rst), .instr_vld(instr_vld), .opcode(opcode),
    .eff_addr(eff_addr), .so_bit(so_bit), .snoop_vld(snoop_vld),
    .snoop_addr(snoop_addr), .wr_permit(wr_permit),
    .sc_success(sc_success), .cr_field(cr_field)
  );

  function automatic int lr_len(input logic [9:0] op);
    case (op)
      10'd52: return 1;  10'd116: return 2;
      10'd20: return 4;  10'd84:  return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int sc_len(input logic [9:0] op);
    case (op)
      10'd694: return 1; 10'd726: return 2;
      10'd150: return 4; 10'd214: return 8;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", cur_tag, what, act, exp, $time);
    end
  endtask

  // one instruction cycle: drive, model, wait for registered outputs, compare
  task automatic step(input bit v, input logic [9:0] op, input logic [63:0] a,
                      input bit so, input bit sv, input logic [63:0] sa);
    int  llen, slen;
    bit  hit, live;
    instr_vld = v; opcode = op; eff_addr = a; so_bit = so;
    snoop_vld = sv; snoop_addr = sa;
    llen = v ? lr_len(op) : 0;
    slen = v ? sc_len(op) : 0;
    hit  = sv && m_vld && (sa[63:3] == m_addr[63:3]);
    live = m_vld && !hit;
    e_pass = 1'b0;
    if (slen != 0) begin
      e_pass = live && (m_len == slen) && (m_addr == a);
      e_cr   = {2'b00, e_pass, so};
    end
    if (llen != 0) begin
      m_vld = 1'b1; m_len = llen; m_addr = a;
    end else if (slen != 0 || hit) begin
      m_vld = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check("wr_permit",  {3'b0, wr_permit},  {3'b0, e_pass});
    check("sc_success", {3'b0, sc_success}, {3'b0, e_pass});
    check("cr_field",   cr_field, e_cr);
  endtask

  task automatic idle();
    step(1'b0, 10'd0, 64'd0, 1'b0, 1'b0, 64'd0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] lrs [4] = '{10'd52, 10'd116, 10'd20, 10'd84};
    logic [9:0] scs [4] = '{10'd694, 10'd726, 10'd150, 10'd214};
    logic [63:0] A = 64'h0000_1234_5678_9AB0;
    logic [63:0] B = 64'h0000_0000_FFFF_0040;
    int unsigned seed_init;
    seed_init = $urandom(32'd20240607);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: outputs zero after reset
    cur_tag = "R10";
    check("cr_field", cr_field, 4'b0000);
    check("wr_permit", {3'b0, wr_permit}, 4'b0000);
    // R10: no reservation after reset, SC fails
    step(1'b1, 10'd150, A, 1'b0, 1'b0, 64'd0);

    // R1 R3 R5: each size pairs successfully
    cur_tag = "R1";
    for (int i = 0; i < 4; i++) begin
      step(1'b1, lrs[i], A + i, 1'b0, 1'b0, 64'd0);
      step(1'b1, scs[i], A + i, 1'b0, 1'b0, 64'd0);
    end
    // R3: size mismatch fails
    cur_tag = "R3";
    step(1'b1, 10'd20, A, 1'b0, 1'b0, 64'd0);
    step(1'b1, 10'd726, A, 1'b0, 1'b0, 64'd0);
    // R3: address off by one fails
    step(1'b1, 10'd84, A, 1'b0, 1'b0, 64'd0);
    step(1'b1, 10'd214, A + 1, 1'b0, 1'b0, 64'd0);
    // R6: second SC after success fails
    cur_tag = "R6";
    step(1'b1, 10'd52, B, 1'b0, 1'b0, 64'd0);
    step(1'b1, 10'd694, B, 1'b0, 1'b0, 64'd0);
    step(1'b1, 10'd694, B, 1'b0, 1'b0, 64'd0);
    // R6: failed SC also disarms
    step(1'b1, 10'd52, B, 1'b0, 1'b0, 64'd0);
    step(1'b1, 10'd694, B + 2, 1'b0, 1'b0, 64'd0);
    step(1'b1, 10'd694, B, 1'b0, 1'b0, 64'd0);
    // R2: newer reservation replaces older
    cur_tag = "R2";
    step(1'b1, 10'd20, A, 1'b0, 1'b0, 64'd0);
    step(1'b1, 10'd20, B, 1'b0, 1'b0, 64'd0);
    step(1'b1, 10'd150, A, 1'b0, 1'b0, 64'd0);
    step(1'b1, 10'd20, A, 1'b0, 1'b0, 64'd0);
    step(1'b1, 10'd20, B, 1'b0, 1'b0, 64'd0);
    step(1'b1, 10'd150, B, 1'b0, 1'b0, 64'd0);
    // R7: snoop in same granule kills, other granule does not
    cur_tag = "R7";
    step(1'b1, 10'd116, A, 1'b0, 1'b0, 64'd0);
    step(1'b0, 10'd0, 64'd0, 1'b0, 1'b1, A ^ 64'd5);
    step(1'b1, 10'd726, A, 1'b0, 1'b0, 64'd0);
    step(1'b1, 10'd116, A, 1'b0, 1'b0, 64'd0);
    step(1'b0, 10'd0, 64'd0, 1'b0, 1'b1, A + 64'd8);
    step(1'b1, 10'd726, A, 1'b0, 1'b0, 64'd0);
    // R8: LR with matching snoop keeps it; SC with matching snoop fails
    cur_tag = "R8";
    step(1'b1, 10'd84, B, 1'b0, 1'b1, B);
    step(1'b1, 10'd214, B, 1'b0, 1'b0, 64'd0);
    step(1'b1, 10'd84, B, 1'b0, 1'b0, 64'd0);
    step(1'b1, 10'd214, B, 1'b0, 1'b1, B + 3);
    // R9: unrelated opcode and unstrobed SC ignored
    cur_tag = "R9";
    step(1'b1, 10'd20, A, 1'b0, 1'b0, 64'd0);
    step(1'b1, 10'd87, B, 1'b0, 1'b0, 64'd0);
    step(1'b0, 10'd150, A, 1'b1, 1'b0, 64'd0);
    step(1'b1, 10'd151, A, 1'b0, 1'b0, 64'd0);
    step(1'b1, 10'd150, A, 1'b0, 1'b0, 64'd0);
    // R4: overflow bit merged, value held while idle
    cur_tag = "R4";
    step(1'b1, 10'd52, A, 1'b0, 1'b0, 64'd0);
    step(1'b1, 10'd694, A, 1'b1, 1'b0, 64'd0);
    idle(); idle();
    step(1'b1, 10'd694, A, 1'b1, 1'b0, 64'd0);
    idle();

    // random mix
    cur_tag = "R5";
    for (int n = 0; n < 4000; n++) begin
      logic [9:0]  op;
      logic [63:0] ad, sa;
      int unsigned r;
      r = $urandom_range(0, 9);
      if (r < 4)      op = lrs[$urandom_range(0, 3)];
      else if (r < 8) op = scs[$urandom_range(0, 3)];
      else            op = 10'($urandom_range(0, 1023));
      ad = (($urandom_range(0, 3) == 0) ? B : A) + 64'($urandom_range(0, 1) * $urandom_range(0, 15));
      sa = (($urandom_range(0, 1) == 0) ? A : B) + 64'($urandom_range(0, 15));
      step(($urandom_range(0, 7) != 0), op, ad, 1'($urandom_range(0, 1)),
           ($urandom_range(0, 5) == 0), sa);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule